// File: doc/BRIEF.md
# Eight-Output Addressable Latch

The block holds eight single-bit storage cells. One data bit is steered into one of them by a binary select code. Two active-low controls pick one of four modes:

- **Write:** the addressed cell follows the data bit.
- **Hold:** nothing changes.
- **Demultiplex:** the addressed output follows the data bit and all other outputs are forced low.
- **Clear:** every output is low.

It serves as a working register, a serial-to-parallel holding register or a 1-of-N decoder with active-high outputs.

By default the cells are level-sensitive latches. Clear and write then act without any clock edge. A parameter selects a registered variant for synchronous fabrics. In that variant, write and demultiplex take effect on the rising clock edge, and the all-clear mode stays asynchronous.

The select lines should only change while the enable is high, so that no stray cell is written. In demultiplex mode the cells keep the pattern they show. The addressed cell holds the data bit and the rest are zero. That pattern is what remains once the block leaves the mode.

Top module: `addr_latch8`

## Requirements
- R1: With clearN high and enableN low, output q[sel] equals dataIn.
- R2: With clearN high and enableN low, every output other than q[sel] keeps its previous value.
- R3: With clearN high and enableN high, all outputs keep their values whatever sel and dataIn do.
- R4: With clearN low and enableN low, q[sel] equals dataIn and every other output is 0.
- R5: With clearN low and enableN high, all outputs are 0 whatever sel and dataIn are.
- R6: sel is an unsigned binary code: value k addresses output bit q[k], for k from 0 to 7.
- R7: After demultiplex mode, the outputs keep that mode's pattern (addressed bit equal to dataIn, others 0) once the block moves to hold or write.
- R8: In the latch variant, all modes take effect without a clock edge. The all-clear mode is also immediate in the registered variant.
- R9: With SYNC_MODE=1, write and demultiplex results appear after the next rising edge of clk.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the registered variant and for the checks |
| clearN | input | 1 | Active-low clear control |
| enableN | input | 1 | Active-low write/demultiplex enable |
| sel | input | 3 | Binary address of the target output |
| dataIn | input | 1 | Data bit steered to the addressed output |
| q | output | 8 | Stored or decoded outputs |

## Verification
A clear and a write can fall in the same cycle. With clearN and enableN both low, the addressed cell is written while all others are cleared.

The bench provokes this case at every select value, with both data levels. It also drops it into random sequences between write and hold vectors. Each result is judged bit by bit against a bench model of the mode table, both right after the inputs change and after the next clock edge. Follow-up hold vectors confirm that the combined pattern is what stays stored.

// File: rtl/addr_latch_pkg.sv
package addr_latch_pkg;

  // Strobes from mode control to the storage array
  typedef struct packed {
    logic writeStrobe;  // addressed cell takes dataBit
    logic clearOthers;  // unaddressed cells forced low
    logic clearAll;     // every cell forced low
    logic dataBit;
  } latchStrobe_t;

endpackage

// File: rtl/addr_latch_ctrl.sv
module addr_latch_ctrl
  import addr_latch_pkg::*;
(
  input  logic         clearN,
  input  logic         enableN,
  input  logic         dataIn,
  output latchStrobe_t strobe
);

  always_comb begin
    strobe.writeStrobe = !enableN;
    strobe.clearOthers = !clearN && !enableN;
    strobe.clearAll    = !clearN && enableN;
    strobe.dataBit     = dataIn;
  end

endmodule

// File: rtl/addr_latch_array.sv
module addr_latch_array
  import addr_latch_pkg::*;
#(
  parameter int SEL_W     = 3,
  parameter bit SYNC_MODE = 1'b0,
  localparam int NUM_OUT  = 1 << SEL_W
) (
  input  logic               clk,
  input  latchStrobe_t       strobe,
  input  logic [SEL_W-1:0]   sel,
  output logic [NUM_OUT-1:0] q
);

  logic clearAllW;
  assign clearAllW = strobe.clearAll;

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_cell
    logic hit, wrEn, clrEn;
    assign hit   = (sel == SEL_W'(i));
    assign wrEn  = strobe.writeStrobe && hit;
    assign clrEn = clearAllW || (strobe.clearOthers && !hit);

    if (SYNC_MODE) begin : g_reg
      always_ff @(posedge clk or posedge clearAllW) begin
        if (clearAllW)  q[i] <= 1'b0;
        else if (clrEn) q[i] <= 1'b0;
        else if (wrEn)  q[i] <= strobe.dataBit;
      end
    end else begin : g_lat
      always_latch begin
        if (clrEn)     q[i] = 1'b0;
        else if (wrEn) q[i] = strobe.dataBit;
      end
    end
  end

  // R5
  clear_all_chk: assert property (@(posedge clk)
    strobe.clearAll |-> (q == '0));

  // R3
  hold_stable_chk: assert property (@(posedge clk) disable iff (strobe.clearAll)
    (!strobe.writeStrobe && $past(!strobe.writeStrobe && !strobe.clearAll)) |-> $stable(q));

  if (!SYNC_MODE) begin : g_latchChk
    // R4
    demux_onehot_chk: assert property (@(posedge clk)
      strobe.clearOthers |-> ($countones(q) <= 1 && q[sel] == strobe.dataBit));

    // R1
    write_follow_chk: assert property (@(posedge clk) disable iff (strobe.clearAll)
      (strobe.writeStrobe && !strobe.clearOthers) |-> (q[sel] == strobe.dataBit));
  end

endmodule

// File: rtl/addr_latch8.sv
module addr_latch8
  import addr_latch_pkg::*;
#(
  parameter int SEL_W     = 3,
  parameter bit SYNC_MODE = 1'b0,
  localparam int NUM_OUT  = 1 << SEL_W
) (
  input  logic               clk,
  input  logic               clearN,
  input  logic               enableN,
  input  logic [SEL_W-1:0]   sel,
  input  logic               dataIn,
  output logic [NUM_OUT-1:0] q
);

  latchStrobe_t strobe;

  addr_latch_ctrl u_ctrl (
    .clearN  (clearN),
    .enableN (enableN),
    .dataIn  (dataIn),
    .strobe  (strobe)
  );

  addr_latch_array #(
    .SEL_W     (SEL_W),
    .SYNC_MODE (SYNC_MODE)
  ) u_array (
    .clk    (clk),
    .strobe (strobe),
    .sel    (sel),
    .q      (q)
  );

endmodule

// File: tb/tb_addr_latch8.sv
module tb_addr_latch8;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       clearN, enableN, dataIn;
  logic [2:0] sel;
  logic [7:0] q, qSync;
  logic [7:0] model;
  int         vecCount = 0;
  int         errCount = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  addr_latch8 #(.SYNC_MODE(1'b0)) dut (
    .clk(clk), .clearN(clearN), .enableN(enableN),
    .sel(sel), .dataIn(dataIn), .q(q));

  addr_latch8 #(.SYNC_MODE(1'b1)) dutSync (
    .clk(clk), .clearN(clearN), .enableN(enableN),
    .sel(sel), .dataIn(dataIn), .q(qSync));

  function automatic logic [7:0] nextState(logic [7:0] prev, logic c, logic e,
                                           logic [2:0] s, logic dv);
    logic [7:0] r;
    r = prev;
    if (!c && e)       r = 8'h00;                      // R5
    else if (!c && !e) r = 8'h00 | (8'(dv) << s);       // R4, R6
    else if (!e)       r[s] = dv;                       // R1, R2
    return r;                                           // R3 hold
  endfunction

  function automatic string modeTag(logic c, logic e);
    if (!c && e)  return "R5";
    if (!c)       return "R4";
    if (!e)       return "R1/R2";
    return "R3";
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    vecCount++;
    if (act !== exp) begin
      errCount++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // Drive at negedge; latch result checked before the clock (R8),
  // registered result checked after the rising edge (R9).
  task automatic applyVec(logic c, logic e, logic [2:0] s, logic dv);
    @(negedge clk);
    clearN = c; enableN = e; sel = s; dataIn = dv;
    model = nextState(model, c, e, s, dv);
    #1;
    check({modeTag(c, e), " R8 latch"}, q, model);
    if (!c && e) check("R8 sync clear", qSync, 8'h00);
    @(posedge clk);
    #1;
    check({modeTag(c, e), " R9 sync"}, qSync, model);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errCount++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, errCount);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    clearN = 1'b0; enableN = 1'b1; sel = 3'd0; dataIn = 1'b0;
    model = 8'h00;
    #2;
    check("R5 reset latch", q, 8'h00);
    check("R5 reset sync", qSync, 8'h00);
    @(posedge clk);

    // R6: each code writes exactly its own bit
    for (int k = 0; k < 8; k++) begin
      applyVec(1'b0, 1'b1, 3'd0, 1'b0);
      applyVec(1'b1, 1'b0, 3'(k), 1'b1);
      check("R6 code position", q, 8'(1) << k);
    end
    // R1, R2: fill all, then knock out bits one by one
    for (int k = 0; k < 8; k++) applyVec(1'b1, 1'b0, 3'(k), 1'b1);
    check("R2 all set", q, 8'hFF);
    for (int k = 0; k < 8; k += 2) applyVec(1'b1, 1'b0, 3'(k), 1'b0);
    check("R2 alternate", q, 8'hAA);
    // R3: hold while sel and data churn
    for (int k = 0; k < 8; k++) applyVec(1'b1, 1'b1, 3'(k), k[0]);
    check("R3 hold", q, 8'hAA);
    // R4: demultiplex at every select with both data levels
    for (int k = 0; k < 8; k++) begin
      applyVec(1'b0, 1'b0, 3'(k), 1'b1);
      check("R4 demux high", q, 8'(1) << k);
      applyVec(1'b0, 1'b0, 3'(k), 1'b0);
      check("R4 demux low", q, 8'h00);
    end
    // R7: pattern left by demultiplex is what stays stored
    applyVec(1'b0, 1'b0, 3'd5, 1'b1);
    applyVec(1'b1, 1'b1, 3'd1, 1'b0);
    check("R7 after demux hold", q, 8'h20);
    applyVec(1'b1, 1'b0, 3'd2, 1'b1);
    check("R7 after demux write", q, 8'h24);
    // R5: clear with every select and data level
    for (int k = 0; k < 8; k++) begin
      applyVec(1'b1, 1'b0, 3'(k), 1'b1);
      applyVec(1'b0, 1'b1, 3'(k), k[1]);
      check("R5 clear", q, 8'h00);
    end
    // Random mix of all four modes
    for (int n = 0; n < 600; n++) begin
      logic [31:0] r;
      r = $urandom;
      applyVec(r[0] | r[1], r[2], r[5:3], r[6]);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vecCount, errCount);
    $finish;
  end

endmodule